// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared RAM and settles collisions when both ports select the same word at once. Each side presents a select (chip enable), an address and a write request. When both sides are selected on one address, the side that arrived later is told to wait through an active-low busy output, and its write strobe toward the array is suppressed until the collision ends.

A mode input picks between two roles. In master mode the block makes the decision itself and drives both busy outputs. In slave mode, used when several arrays are placed side by side to widen the data word, the block makes no decision: the busy lines from an external master arrive as inputs and serve only as write inhibits. The read or write nature of an access never influences who wins.

Top module: `dp_contention_arb`

## Requirements
- R1: In master mode, when the two selects are not both high or the addresses differ, both busy outputs are high.
- R2: In master mode, when a collision begins and exactly one port already held the same select and address in the previous cycle, that earlier port wins and the other port's busy goes low in the cycle the collision begins.
- R3: When both ports reach the colliding state in the same cycle (or neither was steady the cycle before), the left port wins and only the right busy goes low.
- R4: The two busy outputs are never low in the same cycle.
- R5: The write request inputs have no influence on which busy output goes low.
- R6: A port's gated write strobe equals select AND write request, except that it is forced low while that port is blocked (its own busy low in master mode).
- R7: Once chosen, the winner is kept for as long as the collision persists without a break, even if both ports move together to a new shared address.
- R8: The busy of the losing port returns high in the first cycle in which the addresses differ or either select is low.
- R9: In slave mode both busy outputs stay high; a low busy input blocks that port's gated write strobe and a high busy input leaves it equal to select AND write request.
- R10: While reset is asserted with the ports idle, both busy outputs are high and both gated strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = decide and drive busy, 0 = use busy inputs as inhibits |
| l_sel | input | 1 | Left port select |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_sel | input | 1 | Right port select |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left busy from external master (slave mode) |
| r_busy_in_n | input | 1 | Right busy from external master (slave mode) |
| l_busy_n | output | 1 | Left busy, active low (master mode) |
| r_busy_n | output | 1 | Right busy, active low (master mode) |
| l_wr_gated | output | 1 | Left write strobe toward the array |
| r_wr_gated | output | 1 | Right write strobe toward the array |

## Verification
The bench builds the block with its default 11-bit address, so collisions at the top two words and at low addresses use the same comparator width that a 2K-word array needs. A behavioural reference tracks the previous-cycle select and address of each side and the current owner, and is compared on every clock against all four outputs. Scenarios cover staggered arrival from each side, same-cycle ties, a side moving onto the other's steady address, joint address moves that must keep the owner, release by address change and by deselect, and slave mode with busy inputs tied low and high.

// File: rtl/dp_contention_arb.sv
module dp_contention_arb #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_sel,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_gated,
  output logic              r_wr_gated
);
  localparam logic [1:0] OWN_NONE  = 2'd0;
  localparam logic [1:0] OWN_LEFT  = 2'd1;
  localparam logic [1:0] OWN_RIGHT = 2'd2;

  logic [1:0]        owner_q, owner_now;
  logic              l_sel_q, r_sel_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              hit, l_steady, r_steady, l_lose, r_lose, l_block, r_block;

  assign hit      = l_sel && r_sel && (l_addr == r_addr);
  assign l_steady = l_sel && l_sel_q && (l_addr == l_addr_q);
  assign r_steady = r_sel && r_sel_q && (r_addr == r_addr_q);

  always_comb begin
    if (owner_q != OWN_NONE)      owner_now = owner_q;
    else if (r_steady && !l_steady) owner_now = OWN_RIGHT;
    else                          owner_now = OWN_LEFT;
  end

  assign l_lose  = master_mode && hit && (owner_now == OWN_RIGHT);
  assign r_lose  = master_mode && hit && (owner_now == OWN_LEFT);
  assign l_busy_n = !l_lose;
  assign r_busy_n = !r_lose;
  assign l_block = master_mode ? l_lose : !l_busy_in_n;
  assign r_block = master_mode ? r_lose : !r_busy_in_n;
  assign l_wr_gated = l_sel && l_wr && !l_block;
  assign r_wr_gated = r_sel && r_wr && !r_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_sel_q  <= 1'b0;
      r_sel_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q  <= (master_mode && hit) ? owner_now : OWN_NONE;
      l_sel_q  <= l_sel;
      r_sel_q  <= r_sel;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_sel || !r_sel || (l_addr != r_addr)) |-> (l_busy_n && r_busy_n));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (!l_busy_n || !r_busy_n)) |-> (!l_busy_n ? !l_wr_gated : !r_wr_gated));
  p_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && master_mode && $past(master_mode) && hit && $past(hit))
      |-> (l_busy_n == $past(l_busy_n)));
endmodule

// File: tb/dp_contention_arb_test.sv
module dp_contention_arb_test;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0, mm = 1;
  logic ls = 0, lw = 0, rs = 0, rw = 0, lbi = 1, rbi = 1;
  logic [AW-1:0] la = '0, ra = '0;
  logic lb, rb, lg, rg;
  int checks = 0, fails = 0;

  int ref_own = 0;
  logic pl_s = 0, pr_s = 0;
  logic [AW-1:0] pl_a = '0, pr_a = '0;

  always #5 clk = ~clk;

  dp_contention_arb #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(mm),
    .l_sel(ls), .l_addr(la), .l_wr(lw),
    .r_sel(rs), .r_addr(ra), .r_wr(rw),
    .l_busy_in_n(lbi), .r_busy_in_n(rbi),
    .l_busy_n(lb), .r_busy_n(rb), .l_wr_gated(lg), .r_wr_gated(rg));

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive at negedge, compare mid-low phase, then advance model past posedge
  task automatic step(string tag, logic nls, logic [AW-1:0] nla, logic nlw,
                      logic nrs, logic [AW-1:0] nra, logic nrw);
    bit m, lst, rst_, lblk, rblk;
    int own;
    logic elb, erb;
    @(negedge clk);
    ls = nls; la = nla; lw = nlw; rs = nrs; ra = nra; rw = nrw;
    #2;
    m   = ls && rs && (la == ra);
    lst = ls && pl_s && (la == pl_a);
    rst_ = rs && pr_s && (ra == pr_a);
    own = (ref_own != 0) ? ref_own : ((rst_ && !lst) ? 2 : 1);
    elb = !(mm && m && own == 2);
    erb = !(mm && m && own == 1);
    lblk = mm ? !elb : !lbi;
    rblk = mm ? !erb : !rbi;
    chk(tag, "l_busy_n", lb, elb);
    chk(tag, "r_busy_n", rb, erb);
    chk(tag, "l_wr_gated", lg, ls && lw && !lblk);
    chk(tag, "r_wr_gated", rg, rs && rw && !rblk);
    chk("R4", "busy exclusive", !(lb === 1'b0 && rb === 1'b0), 1'b1);
    @(posedge clk);
    ref_own = (mm && m) ? own : 0;
    pl_s = ls; pl_a = la; pr_s = rs; pr_a = ra;
  endtask

  task automatic idle();
    step("R1", 0, '0, 0, 0, '0, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12;
    chk("R10", "reset l_busy_n", lb, 1); chk("R10", "reset r_busy_n", rb, 1);
    chk("R10", "reset l_wr_gated", lg, 0); chk("R10", "reset r_wr_gated", rg, 0);
    @(negedge clk); rst_n = 1;
    idle();
    // R1: different addresses, writes pass
    step("R1", 1, 11'h010, 1, 1, 11'h011, 1);
    step("R1", 1, 11'h7FF, 1, 0, 11'h7FF, 1);
    idle();
    // R2: left first
    step("R2", 1, 11'h7FE, 0, 0, 11'h000, 0);
    step("R2", 1, 11'h7FE, 1, 1, 11'h7FE, 1);
    step("R6", 1, 11'h7FE, 1, 1, 11'h7FE, 1);
    step("R8", 1, 11'h7FE, 1, 1, 11'h7FD, 1);
    idle();
    // R2: right first
    step("R2", 0, 11'h000, 0, 1, 11'h123, 0);
    step("R2", 1, 11'h123, 1, 1, 11'h123, 0);
    step("R8", 0, 11'h123, 1, 1, 11'h123, 1);
    idle();
    // R2: left moves onto right's steady address
    step("R2", 1, 11'h050, 1, 1, 11'h051, 1);
    step("R2", 1, 11'h051, 1, 1, 11'h051, 1);
    idle();
    // R3: same-cycle tie
    step("R3", 1, 11'h2AA, 1, 1, 11'h2AA, 1);
    step("R3", 1, 11'h2AA, 1, 1, 11'h2AA, 1);
    idle();
    // R5: read/write mix does not change winner
    step("R5", 0, 11'h000, 0, 1, 11'h0F0, 1);
    step("R5", 1, 11'h0F0, 1, 1, 11'h0F0, 0);
    step("R5", 1, 11'h0F0, 0, 1, 11'h0F0, 1);
    idle();
    // R7: right owns, both jump together to a new shared address
    step("R7", 0, 11'h000, 0, 1, 11'h333, 1);
    step("R7", 1, 11'h333, 1, 1, 11'h333, 1);
    step("R7", 1, 11'h334, 1, 1, 11'h334, 1);
    step("R7", 1, 11'h001, 1, 1, 11'h001, 1);
    step("R8", 1, 11'h001, 1, 0, 11'h001, 1);
    idle();
    // R9: slave mode
    @(negedge clk); mm = 0; lbi = 1; rbi = 1;
    step("R9", 1, 11'h044, 1, 1, 11'h044, 1);
    @(negedge clk); lbi = 0;
    step("R9", 1, 11'h044, 1, 1, 11'h044, 1);
    step("R9", 1, 11'h100, 1, 1, 11'h200, 1);
    @(negedge clk); lbi = 1; rbi = 0;
    step("R9", 1, 11'h100, 1, 1, 11'h200, 1);
    @(negedge clk); rbi = 1;
    step("R9", 1, 11'h100, 1, 1, 11'h200, 1);
    @(negedge clk); mm = 1;
    idle();
    step("R3", 1, 11'h7FF, 0, 1, 11'h7FF, 0);
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule